// File: doc/BRIEF.md
# Byte-Wide SRAM Bus Controller

This controller sits between a pipelined 16-bit processor and two kinds of target. The first is a page of memory-mapped on-chip peripherals. The second is an external asynchronous SRAM of 32 KB with an 8-bit data path. Each request from the processor carries an address, a size (byte or word), a direction and the store data.

The controller decodes each request and runs it through a small transaction state machine. It drives the peripheral strobes, the external address, the data-pin direction and the two active-low RAM strobes. It raises `txn_rdy` in the one clock cycle in which the transaction finishes.

Both clock edges are used, and every flip-flop is clocked by `clk`. A RAM word read finishes in a single clock. The controller reads the even byte while the clock is high and the odd byte while it is low. Writes are built from half-clock phases, so the write strobe is only low while the address and the data pins are already settled.

The request side works like a valid/ready stream. A request shown with `req_valid` high is taken at a rising edge under two conditions. Either the controller is idle, or `txn_rdy` is high in that cycle, meaning the current transaction finishes there. At any other time `req_valid` is ignored. The requester therefore keeps the next request steady until it sees `txn_rdy`, and only then considers it accepted.

There is no back-pressure towards the peripherals beyond `io_ack`. A peripheral that holds `io_ack` low stretches its transaction by one cycle for each clock it does so.

Top module: `bytesram_memctl`

## Requirements
- R1: A request whose address bits 15:8 equal 0xFF goes to the peripheral page. Every other address goes to the SRAM as `x_addr = addr[14:0]`, so address bit 15 has no effect on a RAM access.
- R2: A request is taken at a rising edge only when `req_valid` is high and the controller is either idle or showing `txn_rdy`. A request shown during an unfinished transaction starts nothing and does not change that transaction's outputs or timing.
- R3: The cycle in which `txn_rdy` is high depends on the transaction type. The first cycle after the accepting edge counts as cycle 1.
  - A RAM read is ready in cycle 1.
  - A RAM byte write is ready in cycle 2.
  - A RAM word write is ready in cycle 3.
  - A peripheral transaction is ready in cycle 1 plus one cycle for each cycle in which `io_ack` is low.
- R4: During a peripheral transaction:
  - `io_sel` is high and `io_addr` equals `addr[7:0]`.
  - A word access raises both lane strobes for its direction (`io_wr_hi`/`io_wr_lo` or `io_rd_hi`/`io_rd_lo`).
  - A byte access raises only the low-lane strobe.
  - `txn_rdy` equals `io_ack`.
- R5: During a RAM read, `x_addr[0]` is 0 in the high half of the clock and 1 in the low half.
  - A word read returns {byte at the even address, byte at the odd address} on `rd_data`.
  - A byte read returns {8'h00, the addressed byte}.
  - `rd_data` changes at the edge that ends the `txn_rdy` cycle.
- R6: A RAM word write stores `wdata[7:0]` at the odd address first and then `wdata[15:8]` at the even address. A byte write stores `wdata[7:0]` at the request address. Each byte written gets exactly one low pulse on `x_we_n`.
- R7: `x_we_n` is low for exactly one half clock, namely W2 and W5 of the write phases. `x_addr` and `x_dout` do not change while it is low.
- R8: The data pins are driven the right way for each state.
  - During RAM writes, `x_dout_en` is high and `x_oe_n` is high.
  - During RAM reads, `x_oe_n` is low and `x_dout_en` is low.
  - While idle or in a peripheral transaction, `x_oe_n` is high and `x_dout_en` is low.
- R9: While `rst_n` is low, `txn_rdy`, `io_sel` and `x_dout_en` are 0, and `x_we_n` and `x_oe_n` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both edges used |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Next-transaction request valid |
| req_addr | input | 16 | Byte address of the request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = 16-bit, 0 = 8-bit |
| req_wdata | input | 16 | Store data (byte stores use bits 7:0) |
| txn_rdy | output | 1 | High in the cycle the transaction completes |
| rd_data | output | 16 | RAM load result |
| io_sel | output | 1 | Peripheral transaction in progress |
| io_addr | output | 8 | Register offset inside the peripheral page |
| io_rd_lo | output | 1 | Peripheral low-lane read strobe |
| io_rd_hi | output | 1 | Peripheral high-lane read strobe |
| io_wr_lo | output | 1 | Peripheral low-lane write strobe |
| io_wr_hi | output | 1 | Peripheral high-lane write strobe |
| io_ack | input | 1 | Peripheral ready; low inserts a wait state |
| x_addr | output | 15 | External SRAM byte address |
| x_dout | output | 8 | Byte driven onto the SRAM data pins |
| x_dout_en | output | 1 | Enable for the SRAM data drivers |
| x_din | input | 8 | Byte read from the SRAM data pins |
| x_we_n | output | 1 | SRAM write enable, active low |
| x_oe_n | output | 1 | SRAM output enable, active low |

## Verification
The bench probes each half of the clock separately, because the work is split between the two halves.

- **Byte order of a read.** A controller that toggled address bit 0 the wrong way round would return reads with their bytes swapped.
- **Write enable against address changes.** A write enable overlapping an address change would corrupt a neighbouring SRAM byte. A behavioural SRAM counts every change of the address or data pins while the write enable is low.
- **Requests shown while busy.** A request shown during an unfinished write must start nothing. A controller that took it early would raise the peripheral select in the middle of the write.
- **Back-to-back transactions.** A read handed over in the ready cycle of a write must follow with no gap. A controller that dropped it would never raise ready for that read.
- **Wait states.** Holding the peripheral acknowledge low must stretch the transaction. A controller that ignored it would finish too early.

// File: rtl/memctl_pkg.sv
package memctl_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int RAM_AW = 15;
  localparam int PAGE_W = ADDR_W - BYTE_W;

  // one-hot so every strobe is a single-flop decode
  typedef enum logic [5:0] {
    ST_IDLE = 6'b000001,
    ST_IO   = 6'b000010,
    ST_RD   = 6'b000100,
    ST_W12  = 6'b001000,
    ST_W34  = 6'b010000,
    ST_W56  = 6'b100000
  } mc_state_e;

  typedef struct packed {
    logic              io;
    logic              write;
    logic              word;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } mc_txn_t;
endpackage

// File: rtl/memctl_decode.sv
module memctl_decode
  import memctl_pkg::*;
#(
  parameter logic [PAGE_W-1:0] IO_PAGE = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic              word,
  input  logic [DATA_W-1:0] wdata,
  output mc_txn_t           txn
);
  always_comb begin
    txn.io    = (addr[ADDR_W-1 -: PAGE_W] == IO_PAGE);
    txn.write = write;
    txn.word  = word;
    txn.addr  = addr;
    txn.wdata = wdata;
  end
endmodule

// File: rtl/memctl_fsm.sv
module memctl_fsm
  import memctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  mc_txn_t   nxt,
  input  logic      io_ack,
  output mc_state_e state,
  output mc_txn_t   cur,
  output logic      rdy,
  output logic      accept
);
  mc_state_e state_d;

  always_comb begin
    unique case (state)
      ST_IO:   rdy = io_ack;
      ST_RD:   rdy = 1'b1;
      ST_W34:  rdy = ~cur.word;
      ST_W56:  rdy = 1'b1;
      default: rdy = 1'b0;
    endcase
  end

  assign accept = req_valid & ((state == ST_IDLE) | rdy);

  always_comb begin
    state_d = state;
    if (accept) begin
      if (nxt.io)         state_d = ST_IO;
      else if (nxt.write) state_d = ST_W12;
      else                state_d = ST_RD;
    end else if ((state == ST_IDLE) || rdy) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state)
        ST_W12:  state_d = ST_W34;
        ST_W34:  state_d = ST_W56;
        default: state_d = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cur   <= '0;
    end else begin
      state <= state_d;
      if (accept) cur <= nxt;
    end
  end
endmodule

// File: rtl/memctl_xbus.sv
module memctl_xbus
  import memctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mc_state_e         state,
  input  mc_txn_t           cur,
  input  logic [BYTE_W-1:0] x_din,
  output logic [RAM_AW-1:0] x_addr,
  output logic [BYTE_W-1:0] x_dout,
  output logic              x_dout_en,
  output logic              x_we_n,
  output logic              x_oe_n,
  output logic [DATA_W-1:0] rd_data
);
  logic              p_tgl, n_tgl, half2;
  logic              n_w12, n_w56;
  logic              a0;
  logic [BYTE_W-1:0] hi_cap;

  // half2 is 0 while clk is high and 1 while clk is low, built only from flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p_tgl <= 1'b0;
    else        p_tgl <= ~p_tgl;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_tgl  <= 1'b0;
      n_w12  <= 1'b0;
      n_w56  <= 1'b0;
      hi_cap <= '0;
    end else begin
      n_tgl <= p_tgl;
      n_w12 <= (state == ST_W12);
      n_w56 <= (state == ST_W56);
      if (state == ST_RD) hi_cap <= x_din;
    end
  end

  assign half2 = (p_tgl == n_tgl);

  always_comb begin
    unique case (state)
      ST_RD:   a0 = half2;
      ST_W12:  a0 = cur.word ? 1'b1 : cur.addr[0];
      ST_W34:  a0 = cur.word ? ~half2 : cur.addr[0];
      ST_W56:  a0 = 1'b0;
      default: a0 = cur.addr[0];
    endcase
  end

  assign x_addr    = {cur.addr[RAM_AW-1:1], a0};
  assign x_dout    = (cur.word && !a0) ? cur.wdata[DATA_W-1:BYTE_W] : cur.wdata[BYTE_W-1:0];
  assign x_dout_en = (state == ST_W12) | (state == ST_W34) | (state == ST_W56);
  assign x_oe_n    = ~(state == ST_RD);
  // W2: low half of W12; W5: high half of W56
  assign x_we_n    = ~(((state == ST_W12) & n_w12) | ((state == ST_W56) & ~n_w56));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (state == ST_RD) begin
      if (cur.word)         rd_data <= {hi_cap, x_din};
      else if (cur.addr[0]) rd_data <= {{BYTE_W{1'b0}}, x_din};
      else                  rd_data <= {{BYTE_W{1'b0}}, hi_cap};
    end
  end
endmodule

// File: rtl/bytesram_memctl.sv
module bytesram_memctl
  import memctl_pkg::*;
#(
  parameter logic [PAGE_W-1:0] IO_PAGE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              txn_rdy,
  output logic [DATA_W-1:0] rd_data,
  output logic              io_sel,
  output logic [BYTE_W-1:0] io_addr,
  output logic              io_rd_lo,
  output logic              io_rd_hi,
  output logic              io_wr_lo,
  output logic              io_wr_hi,
  input  logic              io_ack,
  output logic [RAM_AW-1:0] x_addr,
  output logic [BYTE_W-1:0] x_dout,
  output logic              x_dout_en,
  input  logic [BYTE_W-1:0] x_din,
  output logic              x_we_n,
  output logic              x_oe_n
);
  mc_txn_t   nxt, cur;
  mc_state_e state;
  logic      accept;

  memctl_decode #(.IO_PAGE(IO_PAGE)) u_dec (
    .addr(req_addr), .write(req_write), .word(req_word), .wdata(req_wdata), .txn(nxt)
  );

  memctl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .nxt(nxt), .io_ack(io_ack),
    .state(state), .cur(cur), .rdy(txn_rdy), .accept(accept)
  );

  memctl_xbus u_xbus (
    .clk(clk), .rst_n(rst_n), .state(state), .cur(cur), .x_din(x_din),
    .x_addr(x_addr), .x_dout(x_dout), .x_dout_en(x_dout_en),
    .x_we_n(x_we_n), .x_oe_n(x_oe_n), .rd_data(rd_data)
  );

  assign io_sel   = (state == ST_IO);
  assign io_addr  = cur.addr[BYTE_W-1:0];
  assign io_wr_lo = io_sel & cur.write;
  assign io_wr_hi = io_sel & cur.write & cur.word;
  assign io_rd_lo = io_sel & ~cur.write;
  assign io_rd_hi = io_sel & ~cur.write & cur.word;
endmodule

// File: rtl/memctl_chk.sv
module memctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        nxt_io,
  input logic        nxt_write,
  input logic        nxt_word,
  input logic        txn_rdy,
  input logic        io_sel,
  input logic        io_ack,
  input logic [14:0] x_addr,
  input logic        x_dout_en,
  input logic        x_we_n,
  input logic        x_oe_n
);
  assert_io_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && nxt_io |=> io_sel && x_oe_n && !x_dout_en);

  assert_ram_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !nxt_io |=> !io_sel);

  assert_read_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !nxt_io && !nxt_write |=> txn_rdy && !x_oe_n);

  assert_bwrite_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !nxt_io && nxt_write && !nxt_word |=> !txn_rdy ##1 txn_rdy);

  assert_wwrite_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !nxt_io && nxt_write && nxt_word |=> !txn_rdy ##1 !txn_rdy ##1 txn_rdy);

  assert_io_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |-> (txn_rdy == io_ack));

  assert_we_addr_R7: assert property (@(negedge clk) disable iff (!rst_n)
    !x_we_n |-> $stable(x_addr[14:1]));

  assert_dir_write_R8: assert property (@(negedge clk) disable iff (!rst_n)
    !x_we_n |-> x_dout_en && x_oe_n);

  assert_dir_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !x_oe_n |-> !x_dout_en && !io_sel);
endmodule

bind bytesram_memctl memctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept),
  .nxt_io(nxt.io), .nxt_write(nxt.write), .nxt_word(nxt.word),
  .txn_rdy(txn_rdy), .io_sel(io_sel), .io_ack(io_ack),
  .x_addr(x_addr), .x_dout_en(x_dout_en), .x_we_n(x_we_n), .x_oe_n(x_oe_n)
);

// File: tb/tb_bytesram_memctl.sv
module tb_bytesram_memctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        txn_rdy, io_sel, io_rd_lo, io_rd_hi, io_wr_lo, io_wr_hi;
  logic        io_ack = 1'b1;
  logic [15:0] rd_data;
  logic [7:0]  io_addr, x_dout, x_din;
  logic [14:0] x_addr;
  logic        x_dout_en, x_we_n, x_oe_n;

  int checks = 0, errors = 0, viol = 0, we_pulses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bytesram_memctl dut (.*);

  // behavioural asynchronous SRAM (low 256 bytes)
  logic [7:0] mem [0:255];
  assign x_din = !x_oe_n ? mem[x_addr[7:0]] : 8'hEE;
  always @(posedge x_we_n) if (x_dout_en === 1'b1) mem[x_addr[7:0]] = x_dout;
  always @(negedge x_we_n) we_pulses++;
  always @(x_addr or x_dout) if (x_we_n === 1'b0) viol++;

  task automatic check(input bit ok, input string req, input logic [15:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic wr, wd, input logic [15:0] a, d, input int waits,
                         output int lat, output logic [15:0] rdat,
                         output logic [3:0] lanes, output logic [7:0] ioa);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; lat = 1; io_ack = (waits < 1); #1;
    lanes = {io_rd_hi, io_rd_lo, io_wr_hi, io_wr_lo}; ioa = io_addr;
    while (!txn_rdy && lat < 8) begin
      @(negedge clk); lat++; io_ack = (lat > waits); #1;
    end
    @(negedge clk); #1;
    rdat = rd_data; io_ack = 1;
  endtask

  // {write, word, addr, wdata, exp_rd, chk_rd, exp_lat, lanes{rdhi,rdlo,wrhi,wrlo}, we_pulses}
  localparam int NV = 13;
  localparam logic [59:0] VEC [NV] = '{
    {1'b1,1'b1,16'h0010,16'hABCD,16'h0000,1'b0,3'd3,4'b0000,2'd2}, // R6 word write
    {1'b0,1'b1,16'h0010,16'h0000,16'hABCD,1'b1,3'd1,4'b0000,2'd0}, // R5 word read
    {1'b1,1'b0,16'h0021,16'h005A,16'h0000,1'b0,3'd2,4'b0000,2'd1}, // R6 byte odd
    {1'b1,1'b0,16'h0020,16'h003C,16'h0000,1'b0,3'd2,4'b0000,2'd1}, // R6 byte even
    {1'b0,1'b1,16'h0020,16'h0000,16'h3C5A,1'b1,3'd1,4'b0000,2'd0}, // R5
    {1'b0,1'b0,16'h0021,16'h0000,16'h005A,1'b1,3'd1,4'b0000,2'd0}, // R5 byte odd
    {1'b0,1'b0,16'h0010,16'h0000,16'h00AB,1'b1,3'd1,4'b0000,2'd0}, // R5 byte even
    {1'b1,1'b1,16'h8030,16'h1234,16'h0000,1'b0,3'd3,4'b0000,2'd2}, // R1 bit15 ignored
    {1'b0,1'b1,16'h0030,16'h0000,16'h1234,1'b1,3'd1,4'b0000,2'd0}, // R1
    {1'b1,1'b1,16'hFF04,16'h7777,16'h0000,1'b0,3'd1,4'b0011,2'd0}, // R4 io word wr
    {1'b1,1'b0,16'hFF05,16'h0011,16'h0000,1'b0,3'd1,4'b0001,2'd0}, // R4 io byte wr
    {1'b0,1'b1,16'hFF06,16'h0000,16'h0000,1'b0,3'd1,4'b1100,2'd0}, // R4 io word rd
    {1'b0,1'b0,16'hFF07,16'h0000,16'h0000,1'b0,3'd1,4'b0100,2'd0}  // R4 io byte rd
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int lat, p0;
    logic [15:0] rdat;
    logic [3:0]  lanes;
    logic [7:0]  ioa;

    // R9 reset state
    repeat (3) @(negedge clk);
    check(txn_rdy == 0 && io_sel == 0 && x_dout_en == 0, "R9 reset outputs low",
          {13'd0, txn_rdy, io_sel, x_dout_en}, 16'h0000);
    check(x_we_n == 1 && x_oe_n == 1, "R9 reset strobes high", {14'd0, x_we_n, x_oe_n}, 16'h0003);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      logic [59:0] v;
      v = VEC[i];
      p0 = we_pulses;
      run_txn(v[59], v[58], v[57:42], v[41:26], 0, lat, rdat, lanes, ioa);
      check(lat == int'(v[8:6]), "R3 latency", 16'(lat), 16'(v[8:6]));
      if (v[9]) check(rdat == v[25:10], "R5 read data", rdat, v[25:10]);
      check(lanes == v[5:2], "R4 lane strobes", {12'd0, lanes}, {12'd0, v[5:2]});
      check(we_pulses - p0 == int'(v[1:0]), "R6 we pulses", 16'(we_pulses - p0), 16'(v[1:0]));
      if (v[59:58] == 2'b11 && !v[57])
        check(mem[v[49:42]] == v[41:34] && mem[v[49:42] + 8'd1] == v[33:26],
              "R6 byte order", {mem[v[49:42]], mem[v[49:42] + 8'd1]}, v[41:26]);
    end

    // R4 wait states and io address
    run_txn(1'b0, 1'b1, 16'hFF0A, 16'h0000, 2, lat, rdat, lanes, ioa);
    check(lat == 3, "R4 two wait states", 16'(lat), 16'd3);
    check(ioa == 8'h0A, "R4 io_addr", {8'd0, ioa}, 16'h000A);

    // R5 half-phase address bit 0 during a read
    mem[8'h12] = 8'h56; mem[8'h13] = 8'h78;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_word = 1; req_addr = 16'h0012;
    @(posedge clk); #2;
    check(x_addr == 15'h0012 && !x_oe_n && !x_dout_en, "R5/R8 read first half",
          {1'b0, x_addr}, 16'h0012);
    @(negedge clk); req_valid = 0; #2;
    check(x_addr == 15'h0013, "R5 read second half", {1'b0, x_addr}, 16'h0013);
    @(negedge clk); #1;
    check(rd_data == 16'h5678, "R5 joined word", rd_data, 16'h5678);

    // R7/R8 write half-phases W1..W6
    @(negedge clk);
    req_valid = 1; req_write = 1; req_word = 1; req_addr = 16'h0070; req_wdata = 16'hCAFE;
    @(posedge clk); #2;
    check(x_we_n && x_dout_en && x_oe_n && x_addr[0] && x_dout == 8'hFE, "R7 W1 setup",
          {x_we_n, x_addr[0], 6'd0, x_dout}, 16'hC0FE);
    @(negedge clk); req_valid = 0; #2;
    check(!x_we_n, "R7 W2 strobe low", {15'd0, x_we_n}, 16'h0000);
    @(posedge clk); #2;
    check(x_we_n && x_addr[0], "R7 W3 strobe high", {14'd0, x_we_n, x_addr[0]}, 16'h0003);
    @(negedge clk); #2;
    check(x_we_n && !x_addr[0] && x_dout == 8'hCA, "R7 W4 high byte setup",
          {x_we_n, x_addr[0], 6'd0, x_dout}, 16'h80CA);
    @(posedge clk); #2;
    check(!x_we_n && txn_rdy, "R7 W5 strobe low", {14'd0, x_we_n, txn_rdy}, 16'h0001);
    @(negedge clk); #2;
    check(x_we_n, "R7 W6 strobe high", {15'd0, x_we_n}, 16'h0001);
    @(negedge clk);
    check(mem[8'h70] == 8'hCA && mem[8'h71] == 8'hFE, "R6 word stored",
          {mem[8'h70], mem[8'h71]}, 16'hCAFE);

    // R2 request shown while busy is ignored
    @(negedge clk);
    req_valid = 1; req_write = 1; req_word = 1; req_addr = 16'h0050; req_wdata = 16'hDEAD;
    @(posedge clk);
    @(negedge clk);
    req_addr = 16'hFF00; req_write = 0; #1;
    check(!io_sel && !txn_rdy, "R2 busy cycle1", {14'd0, io_sel, txn_rdy}, 16'h0000);
    @(negedge clk); #1;
    req_valid = 0;
    check(!io_sel && !txn_rdy, "R2 busy cycle2", {14'd0, io_sel, txn_rdy}, 16'h0000);
    @(negedge clk); #1;
    check(txn_rdy && !io_sel, "R2 write still completes in 3", {14'd0, txn_rdy, io_sel}, 16'h0002);
    @(negedge clk); #1;
    check(!io_sel, "R2 no io after", {15'd0, io_sel}, 16'h0000);

    // R2/R3 back-to-back: read handed over in the write's ready cycle
    @(negedge clk);
    req_valid = 1; req_write = 1; req_word = 1; req_addr = 16'h0060; req_wdata = 16'hBEEF;
    @(posedge clk);
    @(negedge clk);
    req_write = 0; #1;
    lat = 1;
    while (!txn_rdy && lat < 8) begin @(negedge clk); #1; lat++; end
    check(lat == 3, "R3 word write before pipelined read", 16'(lat), 16'd3);
    @(negedge clk); req_valid = 0; #1;
    check(txn_rdy && !x_oe_n, "R2 pipelined read starts at once", {14'd0, txn_rdy, x_oe_n}, 16'h0002);
    @(negedge clk); #1;
    check(rd_data == 16'hBEEF, "R5 pipelined read data", rd_data, 16'hBEEF);

    check(viol == 0, "R7 pins changed while we_n low", 16'(viol), 16'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule